// File: doc/BRIEF.md
# Serial Bus Slave with Auto-Incrementing Address Pointer

This block connects a display controller's internal byte address space to a two-wire serial host bus. It acts as an I2C slave at a fixed 7-bit address. It loads a 14-bit address pointer from two bytes that follow the slave byte, and then either accepts write data or returns read data. The pointer advances by one after each data byte. The 14-bit space holds a RAM window, a read-only character ROM window and a bank of sixteen control registers at the top of the map. The rest of the space is unpopulated.

The RAM and ROM are outside the block and are reached through a strobe port. A write raises `mem_wr` for one cycle with the address and the data. A read raises `mem_rd` for one cycle, and the memory must present `mem_rdata` on the second rising clock edge after the edge that raised `mem_rd`, which is a synchronous memory with one cycle of latency. The control registers are inside the block and appear on a flat output vector. Both bus lines are sampled by the fast system clock through synchronizers and a glitch filter. SDA is driven open-drain through `sda_oe`.

Top module: `i2c_ptr_slave`

## Requirements
- R1: The slave address is binary 1011101, so the slave byte is 0xBA for a write and 0xBB for a read. A slave byte that matches is acknowledged. A slave byte that does not match is not acknowledged, and every byte that follows it is ignored and left unacknowledged until the next start.
- R2: In a write, the slave byte is followed by the pointer low byte and then the pointer high byte. Bits 5:0 of the high byte become pointer bits 13:8, and bits 7:6 of the high byte are ignored. Both pointer bytes and every data byte are acknowledged.
- R3: Every byte on the bus is sent and received with the most significant bit first.
- R4: The pointer increments after every data byte, whether written or read, and wraps from 0x3FFF to 0x0000.
- R5: A slave byte with R/W high returns data from consecutive addresses, starting at the stored pointer. Data continues while the host acknowledges. A host NACK ends the transfer, and the block then releases SDA.
- R6: The RAM window is 0x0000 to 0x03FF. A write there gives exactly one single-cycle `mem_wr` pulse carrying `mem_addr` and `mem_wdata`. A read there gives a single-cycle `mem_rd` pulse, and `mem_rdata` is sampled one cycle after the pulse.
- R7: The ROM window is 0x2000 to 0x32FF. It is read through `mem_rd`. Writes to it are acknowledged and discarded, and no `mem_wr` is raised.
- R8: Addresses outside RAM, ROM and the registers read as 0xFF. Writes to them are acknowledged and discarded.
- R9: The control registers occupy 0x3FF0 to 0x3FFF and can be written and read. Register i appears on `cfg_regs[8i+7:8i]`. After reset, registers 0 to 7 hold 0x3F, 0x08, 0x12, 0x00, 0x22, 0x33, 0x28 and 0x0A, and registers 8 to 15 hold 0x00.
- R10: A stop or a repeated start at any bit position aborts the byte in progress without side effects and restarts byte framing.
- R11: The block changes SDA only while the filtered SCL is low. A pulse on SCL shorter than FILT_LEN system clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| mem_rd | output | 1 | One-cycle read strobe to RAM/ROM |
| mem_wr | output | 1 | One-cycle write strobe to RAM |
| mem_addr | output | 14 | Byte address for the strobes |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_rd |
| cfg_regs | output | 128 | Control register contents, register i in byte i |

## Verification
The bench covers the boundaries between regions. It writes across 0x3FFF, where a pointer that failed to wrap would miss the expected RAM write at 0x0000. It reads just inside the ROM window and from the unpopulated gap, where a wrong decode returns RAM data or strobes a write. It sets the two ignored high bits of the pointer high byte, so a design that kept them would aim the write outside RAM. It cuts a data byte short with a stop and cuts a slave byte short with a repeated start, so a design that kept the partial framing would commit a stray write or misread the next slave byte. It also injects sub-filter SCL pulses in the middle of bits, where a design without filtering would gain extra bits and corrupt the data.

// File: rtl/i2c_ptr_pkg.sv
// Shared constants, types and decode helpers for the pointer slave.
// Assumes a 14-bit byte address space with RAM at the bottom, a ROM window
// in the middle and the register bank in the last sixteen bytes.
package i2c_ptr_pkg;
    localparam int          ADDR_W     = 14;
    localparam int          DATA_W     = 8;
    localparam int          NREG       = 16;
    localparam int          RIDX_W     = $clog2(NREG);
    localparam logic [6:0]  SLAVE_ID   = 7'b1011101;
    localparam logic [ADDR_W-1:0] RAM_LAST  = 14'h03FF;
    localparam logic [ADDR_W-1:0] ROM_FIRST = 14'h2000;
    localparam logic [ADDR_W-1:0] ROM_LAST  = 14'h32FF;
    localparam logic [ADDR_W-1:0] CSR_FIRST = 14'h3FF0;

    typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_ALO, ST_AHI, ST_WR, ST_RD} bus_st_t;
    typedef enum logic [1:0] {RG_NONE, RG_RAM, RG_ROM, RG_CSR} region_t;

    // Classify a byte address into its region.
    function automatic region_t region_of(input logic [ADDR_W-1:0] a);
        if (a <= RAM_LAST)                       return RG_RAM;
        else if (a >= ROM_FIRST && a <= ROM_LAST) return RG_ROM;
        else if (a >= CSR_FIRST)                 return RG_CSR;
        else                                     return RG_NONE;
    endfunction

    // Reset value of control register i.
    function automatic logic [DATA_W-1:0] csr_reset(input int i);
        case (i)
            0: return 8'h3F;
            1: return 8'h08;
            2: return 8'h12;
            4: return 8'h22;
            5: return 8'h33;
            6: return 8'h28;
            7: return 8'h0A;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/i2c_line_filter.sv
// Two-flop synchronizer followed by a persistence filter for one bus line.
// The output follows the input only after FILT_LEN consecutive samples that
// disagree with it; shorter pulses are dropped. Resets to the idle level.
module i2c_line_filter #(
    parameter int   FILT_LEN = 3,
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          s1, s2;
    logic [CW-1:0] cnt;

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= IDLE_VAL;
            s2 <= IDLE_VAL;
        end else begin
            s1 <= line_i;
            s2 <= s1;
        end
    end

    // Accept a new level only after it persists for FILT_LEN samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            line_o <= IDLE_VAL;
        end else if (s2 == line_o) begin
            cnt <= '0;
        end else if (cnt == CW'(FILT_LEN - 1)) begin
            cnt    <= '0;
            line_o <= s2;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R11: the filtered level only ever moves to the synchronized level.
    p_filter_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_o) |-> (line_o == $past(s2)));
endmodule

// File: rtl/i2c_csr_bank.sv
// Sixteen 8-bit control registers with individual reset values, one write
// port and one combinational read port. Assumes single-cycle write strobes.
module i2c_csr_bank
    import i2c_ptr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [RIDX_W-1:0]       idx,
    input  logic [DATA_W-1:0]       wd,
    output logic [DATA_W-1:0]       rd,
    output logic [NREG*DATA_W-1:0]  cfg
);
    logic [DATA_W-1:0] regs [NREG];
    logic [NREG*DATA_W-1:0] rst_vec;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Hold register g, loading it on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)                           regs[g] <= csr_reset(g);
            else if (we && idx == RIDX_W'(g))     regs[g] <= wd;
        end
        assign cfg[g*DATA_W +: DATA_W]     = regs[g];
        assign rst_vec[g*DATA_W +: DATA_W] = csr_reset(g);
    end

    assign rd = regs[idx];

    // R9: right after reset every register holds its reset value.
    p_reset_values_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg == rst_vec));
endmodule

// File: rtl/i2c_ptr_slave.sv
// Two-wire bus slave with a 14-bit auto-incrementing byte pointer.
// Decodes start/stop and SCL edges from filtered lines, frames bytes, loads
// the pointer low byte first, then writes or reads consecutive bytes. RAM and
// ROM are external (read latency one cycle); the register bank is internal.
// Assumes clk is many times faster than SCL and no clock stretching is needed.
module i2c_ptr_slave
    import i2c_ptr_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    output logic                   mem_rd,
    output logic                   mem_wr,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [DATA_W-1:0]      mem_wdata,
    input  logic [DATA_W-1:0]      mem_rdata,
    output logic [NREG*DATA_W-1:0] cfg_regs
);
    logic scl_f, sda_f, scl_d, sda_d;
    logic scl_rise, scl_fall, bus_start, bus_stop;

    bus_st_t           state;
    logic [3:0]        bitcnt;
    logic [7:0]        shreg, tx;
    logic [ADDR_W-1:0] ptr;
    logic              mack, sda_oe_q, csr_we;
    logic [1:0]        fp;
    logic [DATA_W-1:0] csr_rd, rd_mux;
    region_t           cur_rg;

    i2c_line_filter #(.FILT_LEN(FILT_LEN), .IDLE_VAL(1'b1)) u_scl (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f));
    i2c_line_filter #(.FILT_LEN(FILT_LEN), .IDLE_VAL(1'b1)) u_sda (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f));

    i2c_csr_bank u_csr (
        .clk(clk), .rst_n(rst_n), .we(csr_we), .idx(mem_addr[RIDX_W-1:0]),
        .wd(mem_wdata), .rd(csr_rd), .cfg(cfg_regs));

    // Delay the filtered lines by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    assign scl_rise  = scl_f & ~scl_d;
    assign scl_fall  = ~scl_f & scl_d;
    assign bus_start = scl_f & scl_d & sda_d & ~sda_f;
    assign bus_stop  = scl_f & scl_d & ~sda_d & sda_f;

    // Select the fetched byte by the region of the latched address.
    always_comb begin
        cur_rg = region_of(mem_addr);
        case (cur_rg)
            RG_RAM, RG_ROM: rd_mux = mem_rdata;
            RG_CSR:         rd_mux = csr_rd;
            default:        rd_mux = 8'hFF;
        endcase
    end

    // Byte framing, pointer handling, acknowledge and transmit control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            tx        <= 8'hFF;
            ptr       <= '0;
            mack      <= 1'b0;
            sda_oe_q  <= 1'b0;
            fp        <= '0;
            mem_rd    <= 1'b0;
            mem_wr    <= 1'b0;
            csr_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_rd <= 1'b0;
            mem_wr <= 1'b0;
            csr_we <= 1'b0;
            fp     <= {fp[0], 1'b0};
            if (fp[1]) tx <= rd_mux;

            if (bus_start) begin
                state    <= ST_DEV;
                bitcnt   <= '0;
                sda_oe_q <= 1'b0;
            end else if (bus_stop) begin
                state    <= ST_IDLE;
                bitcnt   <= '0;
                sda_oe_q <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (scl_rise) begin
                    bitcnt <= bitcnt + 1'b1;
                    if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda_f};
                    else               mack  <= ~sda_f;
                end
                if (scl_fall) begin
                    if (bitcnt == 4'd8) begin
                        sda_oe_q <= 1'b1;
                        case (state)
                            ST_DEV: begin
                                if (shreg[7:1] != SLAVE_ID) begin
                                    sda_oe_q <= 1'b0;
                                    state    <= ST_IDLE;
                                end else if (shreg[0]) begin
                                    mem_addr <= ptr;
                                    mem_rd   <= (region_of(ptr) == RG_RAM) || (region_of(ptr) == RG_ROM);
                                    fp[0]    <= 1'b1;
                                end
                            end
                            ST_ALO: ptr[7:0] <= shreg;
                            ST_AHI: ptr[ADDR_W-1:8] <= shreg[ADDR_W-9:0];
                            ST_WR: begin
                                mem_addr  <= ptr;
                                mem_wdata <= shreg;
                                mem_wr    <= (region_of(ptr) == RG_RAM);
                                csr_we    <= (region_of(ptr) == RG_CSR);
                                ptr       <= ptr + 1'b1;
                            end
                            ST_RD: begin
                                sda_oe_q <= 1'b0;
                                ptr      <= ptr + 1'b1;
                                mem_addr <= ptr + 1'b1;
                                mem_rd   <= (region_of(ptr + 1'b1) == RG_RAM) ||
                                            (region_of(ptr + 1'b1) == RG_ROM);
                                fp[0]    <= 1'b1;
                            end
                            default: sda_oe_q <= 1'b0;
                        endcase
                    end else if (bitcnt == 4'd9) begin
                        bitcnt   <= '0;
                        sda_oe_q <= 1'b0;
                        case (state)
                            ST_DEV: begin
                                state <= shreg[0] ? ST_RD : ST_ALO;
                                if (shreg[0]) sda_oe_q <= ~tx[7];
                            end
                            ST_ALO: state <= ST_AHI;
                            ST_AHI: state <= ST_WR;
                            ST_RD: begin
                                if (mack) sda_oe_q <= ~tx[7];
                                else      state    <= ST_IDLE;
                            end
                            default: state <= state;
                        endcase
                    end else if (state == ST_RD && bitcnt != 4'd0) begin
                        sda_oe_q <= ~tx[3'd7 - bitcnt[2:0]];
                    end
                end
            end
        end
    end

    assign sda_oe = sda_oe_q;

    // R11: SDA is only changed while the filtered clock is low.
    p_sda_moves_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_q) |-> !scl_f);
    // R10: a stop returns to idle with SDA released.
    p_stop_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> (state == ST_IDLE && !sda_oe_q));
    // R4: each written data byte advances the pointer by one.
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR && scl_fall && bitcnt == 4'd8) |=> (ptr == $past(ptr) + 1'b1));
    // R6: strobes last one cycle, and writes only reach the RAM window.
    p_rd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
    p_wr_ram_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (region_of(mem_addr) == RG_RAM && !mem_rd));
endmodule

// File: tb/sim_i2c_ptr_slave.sv
// Scoreboard bench: bus driver tasks push expected RAM writes into a queue,
// a monitor pops and compares them as the design raises mem_wr.
module sim_i2c_ptr_slave;
    localparam int Q = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic        sda_line;
    logic        sda_oe, mem_rd, mem_wr;
    logic [13:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [127:0] cfg_regs;
    logic [7:0]  ram [0:1023];
    logic [21:0] exp_q [$];
    logic [7:0]  wbuf [8];
    logic [7:0]  rbuf [8];
    logic        glitch_en = 1'b0;
    int          n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2c_ptr_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .cfg_regs(cfg_regs));

    function automatic logic [7:0] rom_f(input logic [13:0] a);
        return a[7:0] ^ 8'hC3;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Synchronous memory model, one cycle read latency (R6, R7).
    initial for (int i = 0; i < 1024; i++) ram[i] = 8'h00;
    always @(posedge clk)
        if (mem_rd) mem_rdata <= (mem_addr < 14'd1024) ? ram[mem_addr[9:0]] : rom_f(mem_addr);

    // Monitor: every RAM write must match the head of the queue (R6).
    always @(negedge clk) begin
        if (rst_n && mem_wr) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected write", {18'd0, mem_addr}, 32'hFFFF);
            end else begin
                logic [21:0] e;
                e = exp_q.pop_front();
                chk({mem_addr, mem_wdata} == e, "R6 write addr/data", {mem_addr, mem_wdata}, e);
            end
            ram[mem_addr[9:0]] <= mem_wdata;
        end
    end

    task automatic w(input int n); repeat (n) @(negedge clk); endtask

    task automatic bus_start;
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(2 * Q);
    endtask

    task automatic send_bit(input logic b);
        w(Q); sda_m = b;
        if (glitch_en) begin w(5); scl_m = 1'b1; w(2); scl_m = 1'b0; w(Q - 7); end
        else w(Q);
        scl_m = 1'b1; w(2 * Q); scl_m = 1'b0;
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; w(2 * Q); scl_m = 1'b1; w(Q); b = sda_line; w(Q); scl_m = 1'b0;
    endtask

    // R3: bits go out MSB first.
    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic host_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
        send_bit(~host_ack);
    endtask

    task automatic set_ptr(input logic [7:0] lo, input logic [7:0] hi);
        logic a;
        bus_start;
        send_byte(8'hBA, a); chk(a, "R1 slave ack", a, 1);
        send_byte(lo, a);    chk(a, "R2 addr lo ack", a, 1);
        send_byte(hi, a);    chk(a, "R2 addr hi ack", a, 1);
    endtask

    task automatic do_write(input logic [7:0] lo, input logic [7:0] hi, input int n,
                            input logic [13:0] eaddr);
        logic a;
        set_ptr(lo, hi);
        for (int i = 0; i < n; i++) begin
            logic [13:0] ea;
            ea = eaddr + 14'(i);
            if (ea < 14'd1024) exp_q.push_back({ea, wbuf[i]});
            send_byte(wbuf[i], a); chk(a, "R2 data ack", a, 1);
        end
        bus_stop;
    endtask

    task automatic do_read(input logic [13:0] addr, input int n);
        logic a;
        set_ptr(addr[7:0], {2'b00, addr[13:8]});
        bus_start;
        send_byte(8'hBB, a); chk(a, "R5 read slave ack", a, 1);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        bus_stop;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic a;
        logic [127:0] rv;
        rv = {64'd0, 8'h0A, 8'h28, 8'h33, 8'h22, 8'h00, 8'h12, 8'h08, 8'h3F};
        w(10); rst_n = 1'b1; w(10);
        chk(cfg_regs == rv, "R9 reset values", cfg_regs[31:0], rv[31:0]);
        chk(sda_oe == 1'b0, "R11 sda released after reset", sda_oe, 0);

        // R1 R2 R3 R6: write three bytes to RAM 0x0102.
        wbuf[0] = 8'h81; wbuf[1] = 8'h3C; wbuf[2] = 8'hE7;
        do_write(8'h02, 8'h01, 3, 14'h0102);
        // R5 R3: read them back with a separate sequence.
        do_read(14'h0102, 3);
        chk(rbuf[0] == 8'h81, "R5 read byte0", rbuf[0], 8'h81);
        chk(rbuf[1] == 8'h3C, "R5 read byte1", rbuf[1], 8'h3C);
        chk(rbuf[2] == 8'hE7, "R3 read byte2", rbuf[2], 8'hE7);

        // R1: foreign slave byte and the byte after it are not acknowledged.
        bus_start;
        send_byte(8'hA6, a); chk(!a, "R1 wrong address nack", a, 0);
        send_byte(8'h00, a); chk(!a, "R1 ignored after nack", a, 0);
        bus_stop;

        // R7: ROM writes acked and discarded; reads come via mem_rd.
        wbuf[0] = 8'h55;
        do_write(8'h05, 8'h20, 1, 14'h2005);
        do_read(14'h2005, 2);
        chk(rbuf[0] == rom_f(14'h2005), "R7 rom byte0", rbuf[0], rom_f(14'h2005));
        chk(rbuf[1] == rom_f(14'h2006), "R7 rom byte1", rbuf[1], rom_f(14'h2006));

        // R8: empty space.
        wbuf[0] = 8'h11;
        do_write(8'h00, 8'h10, 1, 14'h1000);
        do_read(14'h1000, 1);
        chk(rbuf[0] == 8'hFF, "R8 empty read", rbuf[0], 8'hFF);

        // R9: register write and read back.
        wbuf[0] = 8'hA5;
        do_write(8'hF3, 8'h3F, 1, 14'h3FF3);
        chk(cfg_regs[31:24] == 8'hA5, "R9 reg3 write", cfg_regs[31:24], 8'hA5);
        do_read(14'h3FF2, 2);
        chk(rbuf[0] == 8'h12, "R9 reg2 read", rbuf[0], 8'h12);
        chk(rbuf[1] == 8'hA5, "R9 reg3 read", rbuf[1], 8'hA5);

        // R4: wrap from the last register to RAM 0x0000.
        wbuf[0] = 8'h77; wbuf[1] = 8'h99;
        do_write(8'hFF, 8'h3F, 2, 14'h3FFF);
        chk(cfg_regs[127:120] == 8'h77, "R4 last reg", cfg_regs[127:120], 8'h77);
        do_read(14'h3FFF, 2);
        chk(rbuf[0] == 8'h77, "R4 read before wrap", rbuf[0], 8'h77);
        chk(rbuf[1] == 8'h99, "R4 read after wrap", rbuf[1], 8'h99);

        // R2: high byte bits 7:6 are ignored.
        wbuf[0] = 8'h5A;
        do_write(8'h10, 8'hC1, 1, 14'h0110);

        // R10: stop inside a data byte commits nothing.
        set_ptr(8'h20, 8'h00);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop;
        do_read(14'h0020, 1);
        chk(rbuf[0] == 8'h00, "R10 aborted byte not written", rbuf[0], 8'h00);

        // R10: repeated start inside a slave byte restarts framing.
        bus_start;
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        wbuf[0] = 8'h6C;
        do_write(8'h30, 8'h00, 1, 14'h0030);

        // R11: sub-filter SCL pulses inside every bit are ignored.
        glitch_en = 1'b1;
        wbuf[0] = 8'hA3;
        do_write(8'h40, 8'h00, 1, 14'h0040);
        glitch_en = 1'b0;
        do_read(14'h0040, 1);
        chk(rbuf[0] == 8'hA3, "R11 glitch immune", rbuf[0], 8'hA3);

        w(20);
        chk(exp_q.size() == 0, "R6 all expected writes seen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule